// File: doc/BRIEF.md
# Cascaded 16-bit Interval Timer

This block joins two 8-bit up-counters into one 16-bit interval timer. A prescaler divides the system clock and produces single-cycle count enables. The low counter advances on the enable picked by a 2-bit clock-select field. Each time the low counter steps onto its compare value, it emits a match pulse and keeps counting. That low-match pulse is the only thing that advances the high counter.

The period closes when a low-match event finds the high counter equal to its own compare value. At that point the low match and the high match coincide. Both counters return to 0, a one-cycle interrupt pulse is issued, and, when inversion is enabled, an output flip-flop toggles. With a nonzero low compare byte, one period lasts high × 256 + low count ticks.

A 2-bit mode field must hold the cascade code, and a run enable must be high, for anything to count. Otherwise the counters rest at 0 and no pulse appears. Everything runs in one clock domain.

Top module: `tmr_cascade16`

## Requirements
- R1: Counting happens only when the mode field is 01 (cascade). With any other mode value, both counters stay at 0, no match or interrupt pulse appears, and the flip-flop output holds its value.
- R2: Clock-select values 00, 01, 10 and 11 give count ticks every 2, 8, 32 and 128 clock cycles. The prescaler starts from zero whenever counting starts.
- R3: The interrupt period is N count ticks. N = high × 256 + low when the low compare byte is nonzero, and N = (high + 1) × 256 when the low compare byte is 0.
- R4: The low match output pulses each time the low counter steps onto the low compare value. The counter is not cleared by that event, so one period contains high + 1 low-match pulses.
- R5: The high match output pulses only in a cycle that also carries a low-match pulse. It pulses exactly once per period.
- R6: The interrupt output is a single-cycle pulse. It coincides with both match outputs.
- R7: The flip-flop output changes only in the cycle of an interrupt pulse. It toggles there when inversion is enabled and holds otherwise.
- R8: While run is low, both counters and the prescaler are held at 0 and no pulse appears. After run rises again, the first interrupt needs a full period.
- R9: After synchronous reset, all four outputs are 0.
- R10: The first interrupt pulse is visible after the (N × divisor)-th rising clock edge counted from the edge at which run is first seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Counting enable |
| mode | input | 2 | Timer mode field; 01 selects cascade operation |
| clk_sel | input | 2 | Low counter tick select: 00 /2, 01 /8, 10 /32, 11 /128 |
| cmp_hi | input | 8 | High counter compare value |
| cmp_lo | input | 8 | Low counter compare value |
| inv_en | input | 1 | Enables flip-flop toggle on interrupt |
| match_lo | output | 1 | Low comparator pulse |
| match_hi | output | 1 | High comparator pulse |
| irq | output | 1 | Period-end interrupt pulse |
| tff_out | output | 1 | Output flip-flop |

## Verification
All four outputs are registered, so every result from a count tick appears one edge after the tick cycle. The first interrupt is therefore visible after exactly N × divisor rising edges from the edge at which run is first seen high. The next interrupt follows N × divisor edges later.

The bench changes inputs on falling edges and samples outputs on the falling edge that follows each rising edge, counting those edges from the start of run. Each measured edge count is compared with the product taken from the vector table. Match pulses are tallied within the window of the first period.

// File: rtl/tmr_cascade_pkg.sv
`timescale 1ns/1ps
package tmr_cascade_pkg;

    localparam int CNT_W  = 8;
    localparam int N_TAPS = 4;

    typedef enum logic [1:0] {
        TM_SPLIT   = 2'b00,
        TM_CASCADE = 2'b01,
        TM_RSV2    = 2'b10,
        TM_RSV3    = 2'b11
    } tmode_e;

    typedef struct packed {
        logic lo_hit;
        logic hi_hit;
        logic wrap;
    } tmr_evt_t;

    // Width of the all-ones window that marks one divider tap (2, 8, 32, 128)
    function automatic int tap_width(input int g);
        return 2 * g + 1;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler
    import tmr_cascade_pkg::*;
#(
    parameter int TAPS = N_TAPS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int PS_W = tap_width(TAPS - 1);

    logic [PS_W-1:0] div_q;
    logic [TAPS-1:0] taps;

    always_ff @(posedge clk) begin
        if (rst || !en) div_q <= '0;
        else            div_q <= div_q + 1'b1;
    end

    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        localparam int TW = tap_width(g);
        assign taps[g] = en && (&div_q[TW-1:0]);
    end

    assign tick = taps[sel];

endmodule

// File: rtl/tmr_lo_stage.sv
`timescale 1ns/1ps
module tmr_lo_stage
    import tmr_cascade_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         tick,
    input  logic         clr,
    input  logic [W-1:0] cmp,
    output logic         arrive
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] nxt;

    assign nxt    = cnt_q + 1'b1;
    assign arrive = tick && (nxt == cmp);

    always_ff @(posedge clk) begin
        if (rst || !en)  cnt_q <= '0;
        else if (tick)   cnt_q <= clr ? '0 : nxt;
    end

endmodule

// File: rtl/tmr_hi_stage.sv
`timescale 1ns/1ps
module tmr_hi_stage
    import tmr_cascade_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         adv,
    input  logic [W-1:0] cmp,
    output logic         hit
);
    logic [W-1:0] cnt_q;

    assign hit = adv && (cnt_q == cmp);

    always_ff @(posedge clk) begin
        if (rst || !en) cnt_q <= '0;
        else if (adv)   cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end

endmodule

// File: rtl/tmr_cascade16.sv
`timescale 1ns/1ps
module tmr_cascade16
    import tmr_cascade_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [1:0]   mode,
    input  logic [1:0]   clk_sel,
    input  logic [W-1:0] cmp_hi,
    input  logic [W-1:0] cmp_lo,
    input  logic         inv_en,
    output logic         match_lo,
    output logic         match_hi,
    output logic         irq,
    output logic         tff_out
);
    logic     active;
    logic     tick;
    logic     lo_arrive;
    logic     hi_hit;
    tmr_evt_t evt_q;
    logic     tff_q;

    assign active = run && (tmode_e'(mode) == TM_CASCADE);

    tmr_prescaler #(.TAPS(N_TAPS)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .en   (active),
        .sel  (clk_sel),
        .tick (tick)
    );

    tmr_lo_stage #(.W(W)) u_lo (
        .clk    (clk),
        .rst    (rst),
        .en     (active),
        .tick   (tick),
        .clr    (hi_hit),
        .cmp    (cmp_lo),
        .arrive (lo_arrive)
    );

    tmr_hi_stage #(.W(W)) u_hi (
        .clk (clk),
        .rst (rst),
        .en  (active),
        .adv (lo_arrive),
        .cmp (cmp_hi),
        .hit (hi_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
            tff_q <= 1'b0;
        end else begin
            evt_q.lo_hit <= lo_arrive;
            evt_q.hi_hit <= hi_hit;
            evt_q.wrap   <= hi_hit;
            if (hi_hit && inv_en) tff_q <= ~tff_q;
        end
    end

    assign match_lo = evt_q.lo_hit;
    assign match_hi = evt_q.hi_hit;
    assign irq      = evt_q.wrap;
    assign tff_out  = tff_q;

endmodule

// File: rtl/tmr_cascade16_chk.sv
`timescale 1ns/1ps
module tmr_cascade16_chk (
    input logic       clk,
    input logic       rst,
    input logic       run,
    input logic [1:0] mode,
    input logic       inv_en,
    input logic       match_lo,
    input logic       match_hi,
    input logic       irq,
    input logic       tff_out
);
    a_r6_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    a_r6_irq_with_matches: assert property (@(posedge clk) disable iff (rst)
        irq |-> (match_lo && match_hi));

    a_r5_hi_needs_lo: assert property (@(posedge clk) disable iff (rst)
        match_hi |-> match_lo);

    a_r7_tff_only_on_irq: assert property (@(posedge clk) disable iff (rst)
        !$stable(tff_out) |-> (irq && $past(inv_en)));

    a_r8_stopped_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(run) |-> !(match_lo || match_hi || irq));

    a_r1_mode_quiet: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) != 2'b01) |-> !(match_lo || match_hi || irq));

    a_r9_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> !(match_lo || match_hi || irq || tff_out));

endmodule

bind tmr_cascade16 tmr_cascade16_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .mode     (mode),
    .inv_en   (inv_en),
    .match_lo (match_lo),
    .match_hi (match_hi),
    .irq      (irq),
    .tff_out  (tff_out)
);

// File: tb/tmr_cascade16_bench.sv
`timescale 1ns/1ps
module tmr_cascade16_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic [1:0] mode = 2'b01;
    logic [1:0] clk_sel = 2'b00;
    logic [7:0] cmp_hi = 8'h00;
    logic [7:0] cmp_lo = 8'h05;
    logic       inv_en = 1'b0;
    logic       match_lo, match_hi, irq, tff_out;

    int n_vec  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tmr_cascade16 u_tmr_cascade16 (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .mode     (mode),
        .clk_sel  (clk_sel),
        .cmp_hi   (cmp_hi),
        .cmp_lo   (cmp_lo),
        .inv_en   (inv_en),
        .match_lo (match_lo),
        .match_hi (match_hi),
        .irq      (irq),
        .tff_out  (tff_out)
    );

    // {clk_sel, cmp_hi, cmp_lo, inv_en, expected ticks per period}
    localparam int NV = 6;
    localparam logic [34:0] VECS [NV] = '{
        {2'd0, 8'h00, 8'h05, 1'b1, 16'd5},
        {2'd1, 8'h00, 8'h03, 1'b0, 16'd3},
        {2'd0, 8'h04, 8'h80, 1'b1, 16'h0480},
        {2'd2, 8'h02, 8'h10, 1'b1, 16'h0210},
        {2'd0, 8'h01, 8'h00, 1'b1, 16'd512},
        {2'd3, 8'h00, 8'h02, 1'b1, 16'd2}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic stop_run(input int cycles);
        run = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    // Measures the edges from run rising to the first and second interrupt
    task automatic measure(input int limit, output int first, output int second,
                           output int lo_n, output int hi_n, output bit tff_first,
                           output bit both_ok, output bit single_ok);
        int  cyc;
        bit  prev;
        cyc = 0; first = 0; second = 0; lo_n = 0; hi_n = 0;
        tff_first = 1'b0; both_ok = 1'b1; single_ok = 1'b1; prev = 1'b0;
        run = 1'b1;
        while (second == 0 && cyc < limit) begin
            @(negedge clk);
            cyc++;
            if (first == 0 && match_lo) lo_n++;
            if (first == 0 && match_hi) hi_n++;
            if (irq && prev) single_ok = 1'b0;
            if (irq) begin
                if (!(match_lo && match_hi)) both_ok = 1'b0;
                if (first == 0) begin
                    first = cyc;
                    tff_first = tff_out;
                end else begin
                    second = cyc;
                end
            end
            prev = irq;
        end
    endtask

    task automatic quiet_window(input int cycles, output int pulses);
        pulses = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (match_lo || match_hi || irq) pulses++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        int  first, second, lo_n, hi_n, pulses, div, nt, exp_cyc;
        bit  tff0, tff1, both_ok, single_ok;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk({match_lo, match_hi, irq, tff_out} == 4'b0, "R9 reset outputs",
            int'({match_lo, match_hi, irq, tff_out}), 0);

        for (int v = 0; v < NV; v++) begin
            stop_run(3);
            mode    = 2'b01;
            clk_sel = VECS[v][34:33];
            cmp_hi  = VECS[v][32:25];
            cmp_lo  = VECS[v][24:17];
            inv_en  = VECS[v][16];
            nt      = int'(VECS[v][15:0]);
            div     = 2 << (2 * int'(clk_sel));
            exp_cyc = nt * div;
            tff0    = tff_out;
            measure(2 * exp_cyc + 20, first, second, lo_n, hi_n, tff1, both_ok, single_ok);
            chk(first == exp_cyc, "R10/R2 first irq latency", first, exp_cyc);
            chk(second - first == exp_cyc, "R3 period", second - first, exp_cyc);
            chk(lo_n == int'(cmp_hi) + 1, "R4 low matches per period", lo_n, int'(cmp_hi) + 1);
            chk(hi_n == 1, "R5 high matches per period", hi_n, 1);
            chk(both_ok, "R6 irq with both matches", int'(both_ok), 1);
            chk(single_ok, "R6 irq single cycle", int'(single_ok), 1);
            chk(tff1 == (tff0 ^ inv_en), "R7 flip-flop on irq", int'(tff1), int'(tff0 ^ inv_en));
        end

        // R8: run low keeps everything quiet
        stop_run(2);
        clk_sel = 2'b00; cmp_hi = 8'h00; cmp_lo = 8'h02; inv_en = 1'b1;
        tff0 = tff_out;
        quiet_window(200, pulses);
        chk(pulses == 0, "R8 no pulses while stopped", pulses, 0);
        chk(tff_out == tff0, "R8 flip-flop holds while stopped", int'(tff_out), int'(tff0));

        // R1: non-cascade mode is idle
        mode = 2'b00;
        run  = 1'b1;
        quiet_window(200, pulses);
        chk(pulses == 0, "R1 mode 00 idle", pulses, 0);
        mode = 2'b10;
        quiet_window(100, pulses);
        chk(pulses == 0, "R1 mode 10 idle", pulses, 0);
        chk(tff_out == tff0, "R1 flip-flop holds in other mode", int'(tff_out), int'(tff0));

        // R8: stop mid-period, restart needs a full period
        stop_run(2);
        mode = 2'b01; cmp_hi = 8'h00; cmp_lo = 8'h40; clk_sel = 2'b00;
        run = 1'b1;
        repeat (100) @(negedge clk);
        stop_run(5);
        measure(300, first, second, lo_n, hi_n, tff1, both_ok, single_ok);
        chk(first == 128, "R8 restart latency", first, 128);

        // R7: inversion disabled keeps the flip-flop
        stop_run(2);
        inv_en = 1'b0;
        tff0 = tff_out;
        measure(300, first, second, lo_n, hi_n, tff1, both_ok, single_ok);
        chk(tff_out == tff0, "R7 no toggle when inversion off", int'(tff_out), int'(tff0));

        // R9: reset mid-run clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk({match_lo, match_hi, irq, tff_out} == 4'b0, "R9 reset mid-run",
            int'({match_lo, match_hi, irq, tff_out}), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule